// File: doc/BRIEF.md
# Vectored Single-Level Interrupt Unit

This block is the interrupt logic of a small 32-bit load/store processor. It owns the program counter and checks one external request line each time the datapath signals an instruction boundary. If the processor is running, the request is high and the global enable flag is set, the block takes the interrupt:

- The current PC goes into a saved-PC register.
- The device's 16-bit cause code goes into an info register.
- The enable flag is cleared.
- The PC jumps to a vector built from the device's 8-bit type code.
- A one-cycle acknowledge pulse goes back to the device in the following cycle.

Otherwise the PC simply advances by four.

Between boundaries the datapath hands the block a decoded opcode and the values of the two register operands. The block executes five interrupt instructions:

- return from interrupt;
- save interrupt state into general registers, through write-enable and write-data outputs;
- restore interrupt state from general registers;
- enable interrupts;
- disable interrupts.

There is no priority scheme. Arbitration among several devices is done outside the block.

Top module: `irq_unit`

## Requirements
- R1: While reset (rst_n low) is asserted and after its release, pc is 0, int_en is 0 and irq_ack is 0.
- R2: A boundary strobe that does not take an interrupt advances pc by 4. This holds when run, irq_req or int_en is low.
- R3: A boundary strobe with run, irq_req and int_en all high makes the following changes:
  - It copies pc into the saved-PC register and irq_info into the info register.
  - It clears int_en.
  - It loads pc with a vector whose bits 31:12 are zero, bits 11:4 are irq_type and bits 3:0 are zero.
- R4: irq_ack is high for exactly one cycle, the cycle after an interrupt is taken, and is low at all other times.
- R5: Return from interrupt (exec_op 29) loads pc from the saved-PC register and sets int_en, both at the same clock edge.
- R6: Save interrupt state (exec_op 16) raises ra_wr_en and rb_wr_en in the same cycle. ra_wr_data carries the info register in bits 15:0 and zeros in bits 31:16. rb_wr_data carries the saved-PC register.
- R7: Restore interrupt state (exec_op 17) loads the info register from bits 15:0 of ra_val and the saved-PC register from rb_val.
- R8: Enable (exec_op 10) sets int_en and disable (exec_op 11) clears it.
- R9: An exec_valid strobe in the same cycle as a boundary strobe is ignored. Any opcode other than 10, 11, 16, 17 and 29 changes neither pc, int_en, the saved-PC register nor the info register. Both write enables stay low except for opcode 16.
- R10: A request still high after a return from interrupt is taken again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Processor running flag |
| boundary | input | 1 | Instruction boundary strobe |
| exec_valid | input | 1 | Interrupt instruction strobe |
| exec_op | input | 5 | Decoded opcode |
| ra_val | input | 32 | Value of register operand ra |
| rb_val | input | 32 | Value of register operand rb |
| irq_req | input | 1 | Device interrupt request |
| irq_info | input | 16 | Device cause code |
| irq_type | input | 8 | Device type code for the vector |
| irq_ack | output | 1 | One-cycle acknowledge pulse |
| pc | output | 32 | Program counter |
| int_en | output | 1 | Global interrupt enable flag |
| ra_wr_en | output | 1 | Write enable for register ra |
| ra_wr_data | output | 32 | Data for register ra |
| rb_wr_en | output | 1 | Write enable for register rb |
| rb_wr_data | output | 32 | Data for register rb |

## Verification
The bench first steps through a handler sequence with fixed stimulus, then runs a long stream of weighted random stimulus, comparing against a bench model every cycle.

The directed part targets several corner cases:
- A request held high across a return. A design that re-enables one instruction late would miss the second entry.
- An instruction strobe colliding with a boundary. A design that acts on both would corrupt the saved PC or re-enable interrupts inside a handler.
- A random vector type code. Using the wrong vector bit placement gives a wrong jump address.
- The acknowledge pulse. Holding it longer than one cycle shows up as irq_ack high in the second cycle.

Save data is checked for zero upper bits, so a sign-extending or unmasked save is caught.

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int XLEN    = 32,
  parameter int INFO_W  = 16,
  parameter int TYPE_W  = 8,
  parameter int VEC_LSB = 4,
  parameter int OP_W    = 5,
  parameter logic [OP_W-1:0] OP_RFI = 5'd29,
  parameter logic [OP_W-1:0] OP_SVI = 5'd16,
  parameter logic [OP_W-1:0] OP_RI  = 5'd17,
  parameter logic [OP_W-1:0] OP_EEN = 5'd10,
  parameter logic [OP_W-1:0] OP_EDI = 5'd11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              boundary,
  input  logic              exec_valid,
  input  logic [OP_W-1:0]   exec_op,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic              irq_req,
  input  logic [INFO_W-1:0] irq_info,
  input  logic [TYPE_W-1:0] irq_type,
  output logic              irq_ack,
  output logic [XLEN-1:0]   pc,
  output logic              int_en,
  output logic              ra_wr_en,
  output logic [XLEN-1:0]   ra_wr_data,
  output logic              rb_wr_en,
  output logic [XLEN-1:0]   rb_wr_data
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0]   pc_q, spc_q;
  logic [INFO_W-1:0] info_q;
  logic              ie_q, ack_q;
  logic              take, act;
  logic [XLEN-1:0]   vector;

  assign take   = boundary & run & irq_req & ie_q;
  assign act    = exec_valid & ~boundary;
  assign vector = XLEN'(irq_type) << VEC_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      spc_q  <= '0;
      info_q <= '0;
      ie_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= take;
      if (boundary) begin
        if (take) begin
          spc_q  <= pc_q;
          info_q <= irq_info;
          ie_q   <= 1'b0;
          pc_q   <= vector;
        end else begin
          pc_q <= pc_q + STEP;
        end
      end else if (act) begin
        case (exec_op)
          OP_RFI: begin
            pc_q <= spc_q;
            ie_q <= 1'b1;
          end
          OP_RI: begin
            info_q <= ra_val[INFO_W-1:0];
            spc_q  <= rb_val;
          end
          OP_EEN:  ie_q <= 1'b1;
          OP_EDI:  ie_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign pc         = pc_q;
  assign int_en     = ie_q;
  assign irq_ack    = ack_q;
  assign ra_wr_en   = act && (exec_op == OP_SVI);
  assign rb_wr_en   = ra_wr_en;
  assign ra_wr_data = XLEN'(info_q);
  assign rb_wr_data = spc_q;

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_ack_ie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !int_en || $past(act));

  p_take_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && run && irq_req && int_en) |=>
      (pc == (XLEN'($past(irq_type)) << VEC_LSB)) && !int_en && irq_ack);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !(run && irq_req && int_en)) |=> pc == $past(pc) + STEP);

  p_rfi_atomic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !boundary && exec_op == OP_RFI) |=> int_en && pc == $past(spc_q));

  p_save_zero_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ra_wr_en |-> ra_wr_data[XLEN-1:INFO_W] == '0);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !exec_valid) |=> $stable(pc) && $stable(int_en));

endmodule

// File: tb/sim_irq_unit.sv
module sim_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic run, boundary, exec_valid, irq_req;
  logic [4:0]  exec_op;
  logic [31:0] ra_val, rb_val;
  logic [15:0] irq_info;
  logic [7:0]  irq_type;
  logic irq_ack, int_en, ra_wr_en, rb_wr_en;
  logic [31:0] pc, ra_wr_data, rb_wr_data;

  int checks = 0, errors = 0;
  logic [31:0] m_pc, m_spc;
  logic [15:0] m_info;
  logic m_ie, m_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_unit u0 (.*);

  function automatic logic [31:0] vec_of(input logic [7:0] t);
    return {20'h0, t, 4'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic bnd, input logic ex, input logic [4:0] op,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic rq, input logic [15:0] inf, input logic [7:0] ty,
                      input logic rn);
    logic tk, ac;
    boundary = bnd; exec_valid = ex; exec_op = op; ra_val = a; rb_val = b;
    irq_req = rq; irq_info = inf; irq_type = ty; run = rn;
    #1;
    ac = ex && !bnd;
    chk("R6/R9 ra_wr_en", {31'h0, ra_wr_en}, {31'h0, ac && op == 5'd16});
    chk("R6/R9 rb_wr_en", {31'h0, rb_wr_en}, {31'h0, ac && op == 5'd16});
    if (ac && op == 5'd16) begin
      chk("R6 ra_wr_data", ra_wr_data, {16'h0, m_info});
      chk("R6 rb_wr_data", rb_wr_data, m_spc);
    end
    tk = bnd && rn && rq && m_ie;
    @(posedge clk);
    m_ack = tk;
    if (bnd) begin
      if (tk) begin m_spc = m_pc; m_info = inf; m_ie = 0; m_pc = vec_of(ty); end
      else m_pc = m_pc + 4;
    end else if (ac) begin
      case (op)
        5'd29: begin m_pc = m_spc; m_ie = 1; end
        5'd17: begin m_info = a[15:0]; m_spc = b; end
        5'd10: m_ie = 1;
        5'd11: m_ie = 0;
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R2/R3/R5 pc", pc, m_pc);
    chk("R3/R5/R8 int_en", {31'h0, int_en}, {31'h0, m_ie});
    chk("R4 irq_ack", {31'h0, irq_ack}, {31'h0, m_ack});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pc = 0; m_spc = 0; m_info = 0; m_ie = 0; m_ack = 0;
    run = 0; boundary = 0; exec_valid = 0; exec_op = 0; ra_val = 0; rb_val = 0;
    irq_req = 0; irq_info = 0; irq_type = 0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk("R1 pc in reset", pc, 0);
    chk("R1 int_en in reset", {31'h0, int_en}, 0);
    chk("R1 irq_ack in reset", {31'h0, irq_ack}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pc after reset", pc, 0);

    // R2: request ignored while disabled, fetch advances
    step(1, 0, 0, 0, 0, 1, 16'h1111, 8'h11, 1);
    chk("R2 pc+4 with int_en low", pc, 32'h4);
    // R8 enable, then request with run low
    step(0, 1, 5'd10, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1, 16'h2222, 8'h22, 0);
    chk("R2 pc+4 with run low", pc, 32'h8);
    // R3 take
    step(1, 0, 0, 0, 0, 1, 16'hBEEF, 8'hA5, 1);
    chk("R3 vector", pc, 32'h0000_0A50);
    chk("R4 ack high", {31'h0, irq_ack}, 1);
    idle();
    chk("R4 ack single cycle", {31'h0, irq_ack}, 0);
    // R6 save shows saved state
    step(0, 1, 5'd16, 0, 0, 1, 0, 0, 1);
    // R9 exec during boundary ignored (edi would clear... use een)
    step(1, 1, 5'd10, 0, 0, 0, 0, 0, 1);
    chk("R9 een with boundary ignored", {31'h0, int_en}, 0);
    step(0, 1, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1);
    step(0, 1, 5'd16, 0, 0, 0, 0, 0, 1);
    // R7 restore then save
    step(0, 1, 5'd17, 32'h1234_5678, 32'h0000_0100, 0, 0, 0, 1);
    step(0, 1, 5'd16, 0, 0, 0, 0, 0, 1);
    // R5 return with request still high; R10 retaken
    step(0, 1, 5'd29, 0, 0, 1, 16'h0042, 8'h07, 1);
    chk("R5 pc from saved", pc, 32'h0000_0100);
    chk("R5 int_en set", {31'h0, int_en}, 1);
    step(1, 0, 0, 0, 0, 1, 16'h0042, 8'h07, 1);
    chk("R10 retaken", pc, 32'h0000_0070);
    step(0, 1, 5'd11, 0, 0, 0, 0, 0, 1);
    chk("R8 disable", {31'h0, int_en}, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      int k = $urandom_range(0, 9);
      case (k)
        0: op = 5'd29; 1: op = 5'd16; 2: op = 5'd17; 3: op = 5'd10;
        4: op = 5'd11; default: op = 5'($urandom);
      endcase
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, op,
           $urandom, $urandom, $urandom_range(0, 1) == 1,
           16'($urandom), 8'($urandom), $urandom_range(0, 7) != 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule